// File: doc/BRIEF.md
# Configurable Multi-Mode I/O Port

This block is the configuration and pin-control logic behind one 8-bit bidirectional I/O port. A microcontroller reaches four per-port registers through a simple synchronous register bus, selecting them by a 2-bit offset from the port's base address. The registers hold output data, pin direction, pin mode and a drive-select value. Every register bit governs the pin with the same index.

Each pin is set on its own as an input or an output. On a port built with mode control, a pin can also leave general I/O and present one bit of an address. That address is captured from a separate address bus while the address-latch strobe is high. Pin levels come back through a two-flop synchronizer and can be read at the data offset. A parameter removes the mode register, and another parameter narrows the port to its four low pins. The drive-select register is storage only and has no effect on any pin.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, the output-data, direction, mode, drive-select and address registers all hold 00h. So pin_oe = 00h, pin_out = 00h, and offsets 1, 2 and 3 read 00h.
- R2: Offset 1 (direction) is written with reg_wen high. pin_oe then equals the written value from the next rising edge on, and not before. A bit value of 1 makes pin i an output (pin_oe[i]=1). A bit value of 0 makes pin i an input.
- R3: A pin whose mode bit is 0 (general I/O) drives pin_out[i] = bit i of the output-data register. That register is written at offset 0.
- R4: A pin whose mode bit is 1 (address out) drives pin_out[i] = bit i of the latched address. The mode register is at offset 2. pin_oe[i] still follows direction bit i.
- R5: The address register takes addr_in on each rising edge where ale is 1. It keeps its value on edges where ale is 0.
- R6: Offsets 1, 2 and 3 read back the direction, mode and drive-select values last written. reg_rdata is combinational from reg_off.
- R7: Offset 0 reads pin_in through a two-flop synchronizer. A change applied before rising edge N is visible after edge N+1, and not after edge N.
- R8: With HAS_MODE_CTRL = 0, offset 2 reads 00h and writes to it are ignored. Every pin behaves as general I/O.
- R9: With PIN_COUNT = 4, bits 7:4 of every register read 00h and writes to them are ignored. pin_out[7:4] and pin_oe[7:4] stay 0.
- R10: Writing the drive-select register (offset 3) changes neither pin_out nor pin_oe.
- R11: With reg_wen low, no register changes, whatever reg_off and reg_wdata hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_off | input | 2 | Register offset: 0 data, 1 direction, 2 mode, 3 drive select |
| reg_wen | input | 1 | Write strobe, applied at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected offset |
| ale | input | 1 | Address-latch strobe |
| addr_in | input | 8 | Address bits to latch |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The hardest situation to bring about is a pin in address-out mode that has to show a latched address different from both its data bit and the current addr_in. To reach it, the stimulus first loads one address, then changes addr_in while the strobe is low, and only then raises the strobe. Mixed mode masks in a vector table put address-driven and data-driven pins side by side on one port. A second, narrow instance without mode control gets identical stimulus, so that the ignored upper bits and the missing mode register show up at its ports.

// File: rtl/port_pkg.sv
package port_pkg;
    localparam int PORT_W = 8;

    typedef logic [PORT_W-1:0] port_t;

    localparam logic [1:0] OFF_DOUT = 2'd0;
    localparam logic [1:0] OFF_DIR  = 2'd1;
    localparam logic [1:0] OFF_MODE = 2'd2;
    localparam logic [1:0] OFF_DRV  = 2'd3;

    typedef struct packed {
        port_t dout;
        port_t dir;
        port_t mode;
        port_t drv;
        port_t addr;
    } cfg_t;

    typedef struct packed {
        port_t s1;
        port_t s2;
    } sync_t;
endpackage

// File: rtl/port_cfg_regs.sv
module port_cfg_regs
    import port_pkg::*;
#(
    parameter int PIN_COUNT     = 8,
    parameter bit HAS_MODE_CTRL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wen,
    input  logic [1:0] reg_off,
    input  port_t      reg_wdata,
    input  logic       ale,
    input  port_t      addr_in,
    output cfg_t       cfg
);
    localparam port_t ACTIVE_MASK = port_t'((1 << PIN_COUNT) - 1);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wen) begin
            case (reg_off)
                OFF_DOUT: cfg_d.dout = reg_wdata & ACTIVE_MASK;
                OFF_DIR:  cfg_d.dir  = reg_wdata & ACTIVE_MASK;
                OFF_MODE: cfg_d.mode = HAS_MODE_CTRL ? (reg_wdata & ACTIVE_MASK) : '0;
                default:  cfg_d.drv  = reg_wdata & ACTIVE_MASK;
            endcase
        end
        if (ale) begin
            cfg_d.addr = addr_in & ACTIVE_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/port_in_sync.sv
module port_in_sync
    import port_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  port_t pin_in,
    output port_t pin_sync
);
    localparam port_t ACTIVE_MASK = port_t'((1 << PIN_COUNT) - 1);

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = pin_in & ACTIVE_MASK;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign pin_sync = sync_q.s2;
endmodule

// File: rtl/port_pin_mux.sv
module port_pin_mux
    import port_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input  port_t dout,
    input  port_t dir,
    input  port_t mode,
    input  port_t addr,
    output port_t pin_out,
    output port_t pin_oe
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        if (i < PIN_COUNT) begin : g_live
            assign pin_out[i] = mode[i] ? addr[i] : dout[i];
            assign pin_oe[i]  = dir[i];
        end else begin : g_dead
            assign pin_out[i] = 1'b0;
            assign pin_oe[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import port_pkg::*;
#(
    parameter int PIN_COUNT     = 8,
    parameter bit HAS_MODE_CTRL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_off,
    input  logic       reg_wen,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ale,
    input  logic [7:0] addr_in,
    input  logic [7:0] pin_in,
    output logic [7:0] pin_out,
    output logic [7:0] pin_oe
);
    cfg_t  cfg;
    port_t pin_sync;

    port_cfg_regs #(.PIN_COUNT(PIN_COUNT), .HAS_MODE_CTRL(HAS_MODE_CTRL)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .ale(ale), .addr_in(addr_in), .cfg(cfg)
    );

    port_in_sync #(.PIN_COUNT(PIN_COUNT)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync)
    );

    port_pin_mux #(.PIN_COUNT(PIN_COUNT)) u_mux (
        .dout(cfg.dout), .dir(cfg.dir), .mode(cfg.mode), .addr(cfg.addr),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always_comb begin
        case (reg_off)
            OFF_DOUT: reg_rdata = pin_sync;
            OFF_DIR:  reg_rdata = cfg.dir;
            OFF_MODE: reg_rdata = cfg.mode;
            default:  reg_rdata = cfg.drv;
        endcase
    end
endmodule

// File: rtl/port_cfg_checker.sv
module port_cfg_checker #(
    parameter int PIN_COUNT     = 8,
    parameter bit HAS_MODE_CTRL = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_off,
    input logic       reg_wen,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [7:0] pin_in,
    input logic [7:0] pin_out,
    input logic [7:0] pin_oe
);
    localparam logic [7:0] ACTIVE_MASK = 8'((1 << PIN_COUNT) - 1);

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_oe_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_off == 2'd1) |=> (pin_oe == ($past(reg_wdata) & ACTIVE_MASK)));

    assert_oe_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wen |=> $stable(pin_oe));

    assert_upper_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out | pin_oe | reg_rdata) & ~ACTIVE_MASK) == 8'h00);

    assert_no_mode_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_MODE_CTRL && reg_off == 2'd2) |-> (reg_rdata == 8'h00));

    assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && reg_off == 2'd0) |-> (reg_rdata == ($past(pin_in, 2) & ACTIVE_MASK)));
endmodule

bind gpio_mux_port port_cfg_checker #(.PIN_COUNT(PIN_COUNT), .HAS_MODE_CTRL(HAS_MODE_CTRL)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_gpio_mux_port.sv
`timescale 1ns/1ps
module test_gpio_mux_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_off = '0;
    logic       reg_wen = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       ale = 1'b0;
    logic [7:0] addr_in = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] rdata_w, out_w, oe_w;
    logic [7:0] rdata_n, out_n, oe_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_mux_port i_gpio_mux_port (
        .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_w), .ale(ale), .addr_in(addr_in), .pin_in(pin_in),
        .pin_out(out_w), .pin_oe(oe_w)
    );

    gpio_mux_port #(.PIN_COUNT(4), .HAS_MODE_CTRL(1'b0)) i_gpio_mux_port_narrow (
        .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_n), .ale(ale), .addr_in(addr_in), .pin_in(pin_in),
        .pin_out(out_n), .pin_oe(oe_n)
    );

    // dout, dir, mode, addr, expected pin_out of the wide port
    localparam logic [39:0] VEC [5] = '{
        {8'hA5, 8'hFF, 8'h00, 8'h3C, 8'hA5},
        {8'hA5, 8'h0F, 8'hFF, 8'h3C, 8'h3C},
        {8'hF0, 8'h33, 8'h0F, 8'h5A, 8'hFA},
        {8'h00, 8'h81, 8'hAA, 8'hFF, 8'hAA},
        {8'h69, 8'h00, 8'hC3, 8'h96, 8'hAA}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] off, input logic [7:0] data);
        @(negedge clk);
        reg_off = off; reg_wdata = data; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic latch(input logic [7:0] a);
        @(negedge clk);
        addr_in = a; ale = 1'b1;
        @(negedge clk);
        ale = 1'b0;
    endtask

    task automatic sel(input logic [1:0] off);
        reg_off = off;
        #1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", oe_w, 8'h00);
        check("R1 pin_out", out_w, 8'h00);
        for (int o = 1; o < 4; o++) begin
            sel(2'(o));
            check("R1 read", rdata_w, 8'h00);
        end

        // R2 R3 R4 table walk, narrow port sees the same writes (R8 R9)
        for (int k = 0; k < 5; k++) begin
            wr(2'd0, VEC[k][39:32]);
            wr(2'd1, VEC[k][31:24]);
            wr(2'd2, VEC[k][23:16]);
            latch(VEC[k][15:8]);
            #1;
            check("R3 R4 pin_out", out_w, VEC[k][7:0]);
            check("R2 pin_oe", oe_w, VEC[k][31:24]);
            check("R8 R9 narrow pin_out", out_n, VEC[k][39:32] & 8'h0F);
            check("R9 narrow pin_oe", oe_n, VEC[k][31:24] & 8'h0F);
        end

        // R2 timing: not before the edge, then after it
        @(negedge clk);
        reg_off = 2'd1; reg_wdata = 8'h5A; reg_wen = 1'b1;
        #1;
        check("R2 before edge", oe_w, 8'h00);
        @(negedge clk);
        reg_wen = 1'b0;
        check("R2 after edge", oe_w, 8'h5A);

        // R11 no write without strobe
        @(negedge clk);
        reg_off = 2'd1; reg_wdata = 8'hFF;
        @(negedge clk);
        check("R11 pin_oe held", oe_w, 8'h5A);

        // R6 read back, R8 R9 narrow read back
        wr(2'd2, 8'hC6);
        wr(2'd3, 8'h5C);
        sel(2'd1); check("R6 dir read", rdata_w, 8'h5A);
        check("R9 narrow dir read", rdata_n, 8'h0A);
        sel(2'd2); check("R6 mode read", rdata_w, 8'hC6);
        check("R8 narrow mode read", rdata_n, 8'h00);
        sel(2'd3); check("R6 drv read", rdata_w, 8'h5C);
        check("R9 narrow drv read", rdata_n, 8'h0C);

        // R10 drive select has no pin effect
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'hA3);
        check("R10 pin_out", out_w, 8'h0F);
        check("R10 pin_oe", oe_w, 8'hFF);

        // R5 latch only with strobe
        latch(8'h21);
        wr(2'd2, 8'hFF);
        check("R5 latched", out_w, 8'h21);
        @(negedge clk);
        addr_in = 8'hDE; ale = 1'b0;
        @(negedge clk);
        check("R5 held without ale", out_w, 8'h21);
        latch(8'hDE);
        check("R5 captured with ale", out_w, 8'hDE);

        // R7 two-flop read-back latency
        @(negedge clk);
        sel(2'd0);
        pin_in = 8'hC3;
        @(negedge clk);
        check("R7 after one edge", rdata_w, 8'h00);
        @(negedge clk);
        check("R7 after two edges", rdata_w, 8'hC3);
        check("R7 R9 narrow read", rdata_n, 8'h03);

        // R1 reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        pin_in = 8'h00;
        #1;
        check("R1 pin_oe after reset", oe_w, 8'h00);
        check("R1 pin_out after reset", out_w, 8'h00);

        finish_run();
    end
endmodule